// File: doc/BRIEF.md
# Frequency-Compensated Nanosecond Time Counter

This block keeps a 64-bit nanosecond time-of-day value for a precision time protocol clock. A 32-bit phase accumulator advances by a programmable addend on every cycle of the reference clock. Each time the accumulator wraps past 2^32, the time value moves forward by a programmable nominal tick period in nanoseconds. When the reference clock runs faster than the nominal tick rate, the addend is set near 2^32 times the nominal-to-reference frequency ratio, rounded up. Software then nudges the addend up or down to trim the clock rate finely, and the counter keeps running while it does so.

Software reaches the block through a small register port with a one-cycle read latency. The time value is split into two 32-bit words. Reading the low word freezes a copy of the high word, so that the next high read returns a matching pair. A write to the low word is parked until the high word is written, and the whole 64-bit value then loads in a single cycle. The control word carries a run enable and the tick period field. Writing the control word to zero stops the timer.

Top module: `ns_timebase`

## Requirements
- R1: After reset, all four registers read zero, reg_rvalid is low, and the timer is stopped.
- R2: The register select on reg_addr works as follows. Value 0 selects the control word: bit 0 is the run enable and bits [16+PER_W-1:16] hold the tick period in ns; all other bits read zero. Value 1 selects the 32-bit addend, value 2 the low time word and value 3 the high time word. A read strobe returns its data with reg_rvalid high exactly one cycle later.
- R3: On every enabled cycle, the phase accumulator adds the addend modulo 2^32. On each wrap, the time value grows by the tick period; for example, addend 0x4000_0000 with period 10 gives exactly +40 ns over any 16 cycles.
- R4: With addend 0x8000_0000 and period 4, the time value grows by exactly 4 on every second reference cycle, which is +40 over any 20 cycles.
- R5: Rewriting the addend while the timer runs changes the rate from the following cycles onward, with no reset and no stop. Changing from 0x8000_0000 to 0x4000_0000 at period 4 gives +20 over 20 cycles.
- R6: While the enable bit is clear, the time value and the phase hold. Writing zero to the control word clears both the enable and the period.
- R7: A read of the low word captures the high word at that moment. A later read of the high word returns that captured value, even if the live high word has changed since.
- R8: A write to the low word does not change the time value. The next write to the high word loads {high, held low} as one 64-bit value in a single cycle.
- R9: If an accumulator wrap falls in the same cycle as a 64-bit load, the load wins and the period is not added. The value read in the next cycle is exactly the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| tod_ns | output | 64 | Live time value in nanoseconds |

## Verification
The assertions assume that a read and a write are never strobed in the same cycle. They also assume that software keeps each low/high write pair together and issues no other count write between its two halves. The bench drives every access through single-operation tasks, so the strobes never overlap and each low write is followed by its high write. The rate checks measure differences between two reads rather than absolute times, because the accumulator phase left by earlier steps is not known to the bench. The chosen addends make the number of wraps in the measured window independent of that starting phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W      = 32;
    localparam int TOD_W       = 2 * DATA_W;
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_PER_LSB = 16;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TOD_W-1:0]  tod_t;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_ADD  = 2'd1,
        SEL_LO   = 2'd2,
        SEL_HI   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic  wrap;
        word_t frac;
    } acc_t;

    function automatic acc_t acc_step(word_t phase, word_t addend);
        logic [DATA_W:0] s;
        s = {1'b0, phase} + {1'b0, addend};
        return acc_t'(s);
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctl,
    input  logic             wr_add,
    input  word_t            wdata,
    output logic             run_en,
    output logic [PER_W-1:0] period,
    output word_t            addend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run_en <= 1'b0;
            period <= '0;
            addend <= '0;
        end else begin
            if (wr_ctl) begin
                run_en <= wdata[CTL_EN_BIT];
                period <= wdata[CTL_PER_LSB +: PER_W];
            end
            if (wr_add) begin
                addend <= wdata;
            end
        end
    end
endmodule

// File: rtl/tmr_phase_acc.sv
module tmr_phase_acc
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run_en,
    input  word_t addend,
    output logic  tick
);
    word_t phase_q;
    acc_t  nxt;

    always_comb begin
        nxt  = acc_step(phase_q, addend);
        tick = run_en & nxt.wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (run_en) begin
            phase_q <= nxt.frac;
        end
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             rd_lo,
    input  word_t            wdata,
    output tod_t             count,
    output word_t            shadow_hi,
    output logic             load,
    output tod_t             load_val
);
    word_t held_lo;
    tod_t  step;

    always_comb begin
        step     = {{(TOD_W-PER_W){1'b0}}, period};
        load     = wr_hi;
        load_val = {wdata, held_lo};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            held_lo   <= '0;
            shadow_hi <= '0;
        end else begin
            if (load) begin
                count <= load_val;
            end else if (tick) begin
                count <= count + step;
            end
            if (wr_lo) begin
                held_lo <= wdata;
            end
            if (rd_lo) begin
                shadow_hi <= count[TOD_W-1:DATA_W];
            end
        end
    end
endmodule

// File: rtl/ns_timebase.sv
module ns_timebase
    import tmr_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rvalid,
    output logic [63:0] tod_ns
);
    localparam int PER_SPAN = CTL_PER_LSB + PER_W;

    logic             wr_ctl, wr_add, wr_lo, wr_hi, rd_lo;
    logic             run_en;
    logic [PER_W-1:0] period;
    word_t            addend;
    logic             tick;
    tod_t             cnt_q;
    word_t            shadow_hi;
    logic             cnt_load;
    tod_t             cnt_load_val;
    word_t            ctl_word;
    tod_t             period_ext;

    always_comb begin
        wr_ctl     = reg_wr && (reg_addr == SEL_CTL);
        wr_add     = reg_wr && (reg_addr == SEL_ADD);
        wr_lo      = reg_wr && (reg_addr == SEL_LO);
        wr_hi      = reg_wr && (reg_addr == SEL_HI);
        rd_lo      = reg_rd && (reg_addr == SEL_LO);
        ctl_word   = '0;
        ctl_word[CTL_EN_BIT] = run_en;
        ctl_word[CTL_PER_LSB +: PER_W] = period;
        period_ext = {{(TOD_W-PER_W){1'b0}}, period};
        tod_ns     = cnt_q;
    end

    generate
        if (PER_SPAN > DATA_W) begin : g_bad_width
            initial $error("PER_W too wide for the control word");
        end
    endgenerate

    tmr_regs #(.PER_W(PER_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_ctl (wr_ctl),
        .wr_add (wr_add),
        .wdata  (reg_wdata),
        .run_en (run_en),
        .period (period),
        .addend (addend)
    );

    tmr_phase_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .addend (addend),
        .tick   (tick)
    );

    tmr_count #(.PER_W(PER_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .period    (period),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .rd_lo     (rd_lo),
        .wdata     (reg_wdata),
        .count     (cnt_q),
        .shadow_hi (shadow_hi),
        .load      (cnt_load),
        .load_val  (cnt_load_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                case (reg_addr)
                    SEL_CTL: reg_rdata <= ctl_word;
                    SEL_ADD: reg_rdata <= addend;
                    SEL_LO:  reg_rdata <= cnt_q[DATA_W-1:0];
                    default: reg_rdata <= shadow_hi;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
    input logic        clk,
    input logic        rst,
    input logic        run_en,
    input logic        load,
    input logic [63:0] load_val,
    input logic [63:0] period_ext,
    input logic [63:0] count,
    input logic        rd,
    input logic        rvalid,
    input logic        wr,
    input logic [1:0]  addr,
    input logic [31:0] wdata
);
    p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !load) |=> $stable(count));

    p_step_size_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> (count == $past(count)) || (count == $past(count) + $past(period_ext)));

    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));

    p_read_lat_r2: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rvalid);

    p_zero_stops_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 2'd0 && wdata == 32'd0) |=> !run_en);
endmodule

bind ns_timebase tmr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .load       (cnt_load),
    .load_val   (cnt_load_val),
    .period_ext (period_ext),
    .count      (cnt_q),
    .rd         (reg_rd),
    .rvalid     (reg_rvalid),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata)
);

// File: tb/tb_ns_timebase.sv
`timescale 1ns/1ps
module tb_ns_timebase;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [63:0] tod_ns;

    always #4 clk = ~clk;

    ns_timebase dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .tod_ns(tod_ns)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic tally(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per returned read
    always @(negedge clk) begin
        if (!rst && reg_rvalid && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            tally(reg_rdata == e.exp, e.tag, reg_rdata, e.exp);
        end
    end

    // all bus tasks start and end at a falling edge
    task automatic bus_wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [31:0] exp, string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_raw(logic [1:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, v2;
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        idle(3);
        tally(reg_rvalid == 1'b0, "R1 rvalid in reset", {31'd0, reg_rvalid}, 32'd0);
        rst = 1'b0;
        idle(1);

        // R1: reset values
        rd_chk(2'd0, 32'h0, "R1 ctl reset");
        rd_chk(2'd1, 32'h0, "R1 addend reset");
        rd_chk(2'd2, 32'h0, "R1 low reset");
        rd_chk(2'd3, 32'h0, "R1 high reset");

        // R2: field positions and masking
        bus_wr(2'd0, 32'hFFFF_FFFF);
        rd_chk(2'd0, 32'h00FF_0001, "R2 ctl fields");
        bus_wr(2'd0, 32'h0);
        bus_wr(2'd1, 32'h8000_0000);
        rd_chk(2'd1, 32'h8000_0000, "R2 addend readback");

        // R8: low write parked, high write loads both halves
        rd_raw(2'd2, v);
        idle(1);
        bus_wr(2'd2, 32'hFFFF_FFF0);
        rd_chk(2'd2, v, "R8 low write alone");
        bus_wr(2'd3, 32'h0000_0001);
        rd_chk(2'd2, 32'hFFFF_FFF0, "R8 loaded low");
        rd_chk(2'd3, 32'h0000_0001, "R8 loaded high");

        // R6: disabled timer holds
        idle(10);
        rd_chk(2'd2, 32'hFFFF_FFF0, "R6 hold while off");

        // R7: shadow of high word across a low-word wrap
        bus_wr(2'd0, 32'h0004_0001);
        rd_raw(2'd2, v);
        idle(20);
        rd_chk(2'd3, (v >= 32'hFFFF_FFF0) ? 32'h1 : 32'h2, "R7 shadow high");
        rd_raw(2'd2, v);
        idle(1);
        rd_chk(2'd3, 32'h2, "R7 fresh high after wrap");

        // R4: period 4 every second cycle
        rd_raw(2'd2, v);
        idle(19);
        rd_chk(2'd2, v + 32'd40, "R4 rate 0x80000000/4");

        // R5: trim addend while running
        bus_wr(2'd1, 32'h4000_0000);
        idle(2);
        rd_raw(2'd2, v);
        idle(19);
        rd_chk(2'd2, v + 32'd20, "R5 trimmed rate");

        // R3: other period
        bus_wr(2'd0, 32'h000A_0001);
        idle(2);
        rd_raw(2'd2, v);
        idle(15);
        rd_chk(2'd2, v + 32'd40, "R3 addend 0x40000000 period 10");

        // R9: load in a wrap cycle wins
        bus_wr(2'd1, 32'hFFFF_FFFF);
        bus_wr(2'd0, 32'h0005_0001);
        idle(3);
        bus_wr(2'd2, 32'h0000_1234);
        bus_wr(2'd3, 32'h0000_0000);
        rd_chk(2'd2, 32'h0000_1234, "R9 load beats wrap");

        // R6: zero control stops timer
        bus_wr(2'd0, 32'h0);
        idle(1);
        rd_raw(2'd2, v2);
        idle(10);
        rd_chk(2'd2, v2, "R6 stopped by zero ctl");
        rd_chk(2'd0, 32'h0, "R6 ctl cleared");

        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule